// File: doc/BRIEF.md
# Pipelined Floating-Point Divider

This block divides one compact floating-point operand by another and returns the quotient in the same format. A number has a sign bit, a two's-complement exponent and a stored mantissa fraction. The leading mantissa bit is always one and is not stored, so every non-zero magnitude lies in [0.5, 1) times a power of two. The mantissa quotient comes from an unrolled non-restoring array. Each register stage holds one conditional add-or-subtract step and yields one quotient bit. A new operand pair may therefore enter on every clock, and results leave in issue order after a fixed latency.

The exponent of the result is the dividend exponent minus the divisor exponent, and the result sign is the exclusive-or of the operand signs. A mantissa ratio of one or more is brought back into range by a single right shift that also raises the exponent by one. The result is then rounded on the first discarded quotient bit. Three further cases are handled: a zero divisor raises a flag and returns the largest magnitude, results beyond the exponent range saturate, and results below it become zero.

Top module: `fpdiv_top`

## Requirements
- R1: A word is {sign at bit WORD_W-1, exponent at bits WORD_W-2..MAN_W in two's complement, stored fraction at bits MAN_W-1..0}. A non-zero word has the value (-1)^sign · (0.5 + fraction/2^(MAN_W+1)) · 2^exponent. The exponent code -2^(EXP_W-1) marks zero whatever the other fields hold.
- R2: For non-zero operands whose mantissa ratio is below one, the result sign is the XOR of the operand signs and the result exponent is the dividend exponent minus the divisor exponent.
- R3: When the dividend mantissa is greater than or equal to the divisor mantissa, the quotient is shifted right by one place and the exponent is increased by one.
- R4: The stored fraction is the truncated quotient plus the first discarded quotient bit, so a remainder of half a unit or more rounds the magnitude up.
- R5: An operand pair is accepted on every cycle in which in_valid is high. Its result appears with out_valid high exactly MAN_W+5 clock cycles later, and results keep issue order.
- R6: A zero divisor sets div_zero high with out_valid and returns the sign XOR, exponent 2^(EXP_W-1)-1 and an all-ones fraction. This holds even when the dividend is also zero.
- R7: A zero dividend with a non-zero divisor returns the canonical zero word: sign 0, exponent code -2^(EXP_W-1), fraction 0.
- R8: A final exponent above 2^(EXP_W-1)-1 returns the sign XOR, the largest exponent and an all-ones fraction, with div_zero low.
- R9: A final exponent below -2^(EXP_W-1)+1 returns the canonical zero word. A final exponent equal to that bound is kept as a normal result.
- R10: While rst is high, and on the first cycle after it, out_valid and div_zero are low. Operations in flight when reset is applied never produce output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| dividend | input | WORD_W | Numerator operand |
| divisor | input | WORD_W | Denominator operand |
| out_valid | output | 1 | Result present this cycle |
| quotient | output | WORD_W | Rounded quotient |
| div_zero | output | 1 | Divisor was zero for this result |

## Verification
Fixed operand pairs with hand-computed results pin down the encoding and two other behaviours. Ratios below one show the plain exponent difference, and a ratio of one and a half shows the shift-and-increment path. A pair whose first discarded bit is one shows that rounding adds it. Exponent pairs set exactly at and one past both range limits tell saturation and flush-to-zero apart from the normal results next to them. Zero operands, including a negative-signed zero and zero over zero, separate the flagged case from the plain zero result. A long back-to-back stream of random operands checks bit-exact quotients and the fixed latency under full load, and a reset applied mid-stream must discard everything in flight.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

    localparam int DEF_EXP_W = 6;
    localparam int DEF_MAN_W = 14;

    typedef enum logic [1:0] {
        RES_NORMAL   = 2'd0,
        RES_ZERO     = 2'd1,
        RES_SATURATE = 2'd2
    } res_class_e;

    // Priority: zero divisor first, then zero dividend, then range limits.
    function automatic res_class_e pick_class(
        input logic a_zero,
        input logic b_zero,
        input logic too_big,
        input logic too_small
    );
        if (b_zero)    return RES_SATURATE;
        if (a_zero)    return RES_ZERO;
        if (too_big)   return RES_SATURATE;
        if (too_small) return RES_ZERO;
        return RES_NORMAL;
    endfunction

endpackage

// File: rtl/fpdiv_unpack.sv
module fpdiv_unpack #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 14,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int XW = EXP_W + 2
) (
    input  logic [WORD_W-1:0] num_word,
    input  logic [WORD_W-1:0] den_word,
    output logic              sgn,
    output logic [XW-1:0]     ediff,
    output logic              a_zero,
    output logic              b_zero,
    output logic [MAN_W:0]    n_man,
    output logic [MAN_W:0]    d_man
);
    localparam logic [EXP_W-1:0] ZCODE = {1'b1, {(EXP_W-1){1'b0}}};

    logic [EXP_W-1:0] ea, eb;

    always_comb begin
        ea     = num_word[WORD_W-2:MAN_W];
        eb     = den_word[WORD_W-2:MAN_W];
        sgn    = num_word[WORD_W-1] ^ den_word[WORD_W-1];
        a_zero = (ea == ZCODE);
        b_zero = (eb == ZCODE);
        // sign-extend both exponents before subtracting
        ediff  = {{2{ea[EXP_W-1]}}, ea} - {{2{eb[EXP_W-1]}}, eb};
        n_man  = {1'b1, num_word[MAN_W-1:0]};
        d_man  = {1'b1, den_word[MAN_W-1:0]};
    end
endmodule

// File: rtl/fpdiv_nr_step.sv
module fpdiv_nr_step #(
    parameter int MAN_W = 14,
    parameter int IDX = 0,
    localparam int RW = MAN_W + 4,
    localparam int QB = MAN_W + 3
) (
    input  logic signed [RW-1:0] rem_i,
    input  logic [QB-1:0]        q_i,
    input  logic [MAN_W:0]       d_i,
    output logic signed [RW-1:0] rem_o,
    output logic [QB-1:0]        q_o
);
    logic signed [RW-1:0] d_x;
    assign d_x = $signed({3'b000, d_i});

    generate
        if (IDX == 0) begin : g_first
            // integer-weight step: plain trial subtraction
            always_comb rem_o = rem_i - d_x;
        end else begin : g_rest
            logic signed [RW-1:0] dbl;
            always_comb begin
                dbl   = rem_i <<< 1;
                // previous quotient bit set means previous remainder was non-negative
                rem_o = q_i[QB-IDX] ? (dbl - d_x) : (dbl + d_x);
            end
        end
    endgenerate

    always_comb begin
        q_o             = q_i;
        q_o[QB-1-IDX]   = ~rem_o[RW-1];
    end
endmodule

// File: rtl/fpdiv_round_pack.sv
module fpdiv_round_pack
    import fpdiv_pkg::*;
#(
    parameter int EXP_W = 6,
    parameter int MAN_W = 14,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int XW = EXP_W + 2,
    localparam int QB = MAN_W + 3
) (
    input  logic              sgn,
    input  logic [XW-1:0]     ediff,
    input  logic              a_zero,
    input  logic              b_zero,
    input  logic [QB-1:0]     qbits,
    output logic [WORD_W-1:0] word
);
    localparam int EMAX = 2**(EXP_W-1) - 1;
    localparam int EMIN_NZ = -(2**(EXP_W-1)) + 1;
    localparam logic signed [XW-1:0] EMAX_S = XW'(EMAX);
    localparam logic signed [XW-1:0] EMIN_S = XW'(EMIN_NZ);
    localparam logic [EXP_W-1:0] ZCODE = {1'b1, {(EXP_W-1){1'b0}}};
    localparam logic [EXP_W-1:0] MAXCODE = {1'b0, {(EXP_W-1){1'b1}}};

    logic             ge_one, guard, carry;
    logic [MAN_W-1:0] frac, frac_r;
    logic [1:0]       incr;
    logic [XW-1:0]    fexp;
    res_class_e       cls;

    always_comb begin
        ge_one = qbits[QB-1];
        frac   = ge_one ? qbits[QB-2:2] : qbits[QB-3:1];
        guard  = ge_one ? qbits[1] : qbits[0];
        carry  = guard & (&frac);
        frac_r = frac + MAN_W'(guard);
        incr   = {1'b0, ge_one} + {1'b0, carry};
        fexp   = ediff + XW'(incr);
        cls    = pick_class(a_zero, b_zero,
                            $signed(fexp) > EMAX_S,
                            $signed(fexp) < EMIN_S);
        unique case (cls)
            RES_ZERO:     word = {1'b0, ZCODE, {MAN_W{1'b0}}};
            RES_SATURATE: word = {sgn, MAXCODE, {MAN_W{1'b1}}};
            default:      word = {sgn, fexp[EXP_W-1:0], frac_r};
        endcase
    end
endmodule

// File: rtl/fpdiv_top.sv
module fpdiv_top
    import fpdiv_pkg::*;
#(
    parameter int EXP_W = DEF_EXP_W,
    parameter int MAN_W = DEF_MAN_W,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] dividend,
    input  logic [WORD_W-1:0] divisor,
    output logic              out_valid,
    output logic [WORD_W-1:0] quotient,
    output logic              div_zero
);
    localparam int XW = EXP_W + 2;
    localparam int RW = MAN_W + 4;
    localparam int STAGES = MAN_W + 3;

    typedef struct packed {
        logic          sgn;
        logic [XW-1:0] ediff;
        logic          a_zero;
        logic          b_zero;
    } side_t;

    side_t                side_in;
    logic [MAN_W:0]       n_man, d_man;

    logic                 v_a    [0:STAGES];
    side_t                side_a [0:STAGES];
    logic signed [RW-1:0] rem_a  [0:STAGES];
    logic [STAGES-1:0]    q_a    [0:STAGES];
    logic [MAN_W:0]       d_a    [0:STAGES];

    logic signed [RW-1:0] rem_n  [0:STAGES-1];
    logic [STAGES-1:0]    q_n    [0:STAGES-1];

    logic [WORD_W-1:0]    packed_word;

    fpdiv_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
        .num_word (dividend),
        .den_word (divisor),
        .sgn      (side_in.sgn),
        .ediff    (side_in.ediff),
        .a_zero   (side_in.a_zero),
        .b_zero   (side_in.b_zero),
        .n_man    (n_man),
        .d_man    (d_man)
    );

    generate
        for (genvar j = 0; j < STAGES; j++) begin : g_step
            fpdiv_nr_step #(.MAN_W(MAN_W), .IDX(j)) u_step (
                .rem_i (rem_a[j]),
                .q_i   (q_a[j]),
                .d_i   (d_a[j]),
                .rem_o (rem_n[j]),
                .q_o   (q_n[j])
            );
        end
    endgenerate

    fpdiv_round_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
        .sgn    (side_a[STAGES].sgn),
        .ediff  (side_a[STAGES].ediff),
        .a_zero (side_a[STAGES].a_zero),
        .b_zero (side_a[STAGES].b_zero),
        .qbits  (q_a[STAGES]),
        .word   (packed_word)
    );

    // valid chain: the only state that needs reset
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j <= STAGES; j++) v_a[j] <= 1'b0;
            out_valid <= 1'b0;
            div_zero  <= 1'b0;
        end else begin
            v_a[0] <= in_valid;
            for (int j = 0; j < STAGES; j++) v_a[j+1] <= v_a[j];
            out_valid <= v_a[STAGES];
            div_zero  <= v_a[STAGES] & side_a[STAGES].b_zero;
        end
    end

    // datapath registers, one step of the array per stage
    always_ff @(posedge clk) begin
        side_a[0] <= side_in;
        rem_a[0]  <= $signed({3'b000, n_man});
        q_a[0]    <= '0;
        d_a[0]    <= d_man;
        for (int j = 0; j < STAGES; j++) begin
            side_a[j+1] <= side_a[j];
            rem_a[j+1]  <= rem_n[j];
            q_a[j+1]    <= q_n[j];
            d_a[j+1]    <= d_a[j];
        end
        quotient <= packed_word;
    end
endmodule

// File: rtl/fpdiv_chk.sv
module fpdiv_chk #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 14,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int RW = MAN_W + 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [WORD_W-1:0]    quotient,
    input logic                 div_zero,
    input logic                 fin_valid,
    input logic signed [RW-1:0] rem_fin,
    input logic [MAN_W:0]       d_fin
);
    localparam int LAT = MAN_W + 5;
    localparam int CW = $clog2(LAT + 2) + 1;
    localparam logic [EXP_W-1:0] ZCODE = {1'b1, {(EXP_W-1){1'b0}}};
    localparam logic [EXP_W-1:0] MAXCODE = {1'b0, {(EXP_W-1){1'b1}}};

    logic [CW-1:0]        inflight;
    logic signed [RW-1:0] d_s;
    assign d_s = $signed({3'b000, d_fin});

    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else     inflight <= inflight + CW'(in_valid) - CW'(out_valid);
    end

    p_rst_idle_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && !div_zero));

    p_dz_valid_r6: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> out_valid);

    p_dz_maxmag_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && div_zero) |->
        (quotient[WORD_W-2:MAN_W] == MAXCODE && &quotient[MAN_W-1:0]));

    // R7 and R9: any zero result leaves in canonical form
    p_zero_canon_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && quotient[WORD_W-2:MAN_W] == ZCODE) |->
        (quotient[MAN_W-1:0] == '0 && !quotient[WORD_W-1]));

    p_rem_bound_r2: assert property (@(posedge clk) disable iff (rst)
        fin_valid |-> (rem_fin >= -d_s && rem_fin < d_s));

    p_out_has_src_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));

    p_inflight_cap_r5: assert property (@(posedge clk) disable iff (rst)
        inflight <= CW'(LAT));
endmodule

bind fpdiv_top fpdiv_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .quotient  (quotient),
    .div_zero  (div_zero),
    .fin_valid (v_a[STAGES]),
    .rem_fin   (rem_a[STAGES]),
    .d_fin     (d_a[STAGES])
);

// File: tb/sim_fpdiv_top.sv
`timescale 1ns/1ps
module sim_fpdiv_top;
    localparam int EW = 6;
    localparam int MW = 14;
    localparam int W = 1 + EW + MW;
    localparam int LAT = MW + 5;
    localparam int EMAX = 2**(EW-1) - 1;
    localparam int EMIN = -(2**(EW-1));
    localparam int FULL = (1 << MW) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         out_valid, div_zero;
    logic [W-1:0] quotient;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fpdiv_top #(.EXP_W(EW), .MAN_W(MW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .dividend  (dividend),
        .divisor   (divisor),
        .out_valid (out_valid),
        .quotient  (quotient),
        .div_zero  (div_zero)
    );

    typedef struct {
        logic [W:0] want;
        int         at;
        string      tag;
    } item_t;

    item_t pend[$];
    item_t mon_it;

    function automatic logic [W-1:0] mk(input logic s, input int e, input int m);
        logic [EW-1:0] ef = e[EW-1:0];
        return {s, ef, m[MW-1:0]};
    endfunction

    // expected {div_zero, word}, worked out from the requirements
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        logic   sa = a[W-1];
        logic   sb = b[W-1];
        int     ea = int'($signed(a[W-2:MW]));
        int     eb = int'($signed(b[W-2:MW]));
        longint n  = (longint'(1) <<< MW) + longint'(a[MW-1:0]);
        longint d  = (longint'(1) <<< MW) + longint'(b[MW-1:0]);
        longint t, r;
        int     e;
        if (eb == EMIN) return {1'b1, mk(sa ^ sb, EMAX, FULL)};
        if (ea == EMIN) return {1'b0, mk(1'b0, EMIN, 0)};
        if (n >= d) begin
            t = (n <<< (MW + 1)) / d;
            e = ea - eb + 1;
        end else begin
            t = (n <<< (MW + 2)) / d;
            e = ea - eb;
        end
        r = (t >>> 1) + (t & 1);
        if (r >= (longint'(1) <<< (MW + 1))) begin
            r = longint'(1) <<< MW;
            e = e + 1;
        end
        if (e > EMAX) return {1'b0, mk(sa ^ sb, EMAX, FULL)};
        if (e < EMIN + 1) return {1'b0, mk(1'b0, EMIN, 0)};
        return {1'b0, mk(sa ^ sb, e, int'(r - (longint'(1) <<< MW)))};
    endfunction

    task automatic push_op(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W:0] want, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        dividend = a;
        divisor  = b;
        it.want = want;
        it.at   = cyc;
        it.tag  = tag;
        pend.push_back(it);
    endtask

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        push_op(a, b, model(a, b), tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pop and compare each result as it appears
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            compared++;
            if (pend.size() == 0) begin
                mismatched++;
                $display("FAIL R5/R10: unexpected result, actual dz=%0b q=%h, expected no output",
                         div_zero, quotient);
            end else begin
                mon_it = pend.pop_front();
                if ({div_zero, quotient} !== mon_it.want || (cyc - mon_it.at) != LAT) begin
                    mismatched++;
                    $display("FAIL %s: actual dz=%0b q=%h after %0d cycles, expected dz=%0b q=%h after %0d cycles",
                             mon_it.tag, div_zero, quotient, cyc - mon_it.at,
                             mon_it.want[W], mon_it.want[W-1:0], LAT);
                end
            end
        end
    end

    initial begin
        #1600000;
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual run still active, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        bit bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compared++;   // R10 reset state
        if (out_valid !== 1'b0 || div_zero !== 1'b0) begin
            mismatched++;
            $display("FAIL R10: actual out_valid=%0b div_zero=%0b, expected 0 0", out_valid, div_zero);
        end

        // R1: 0.75*2 / 0.75 = 2 -> 0.5 * 2^2
        push_op(mk(0, 1, 1 << (MW-1)), mk(0, 0, 1 << (MW-1)), {1'b0, mk(0, 2, 0)}, "R1");
        // R2: -0.5 / 0.75, ratio below one, fraction 5461
        push_op(mk(1, 0, 0), mk(0, 0, 1 << (MW-1)), {1'b0, mk(1, 0, 5461)}, "R2");
        // R2/R3: signs and negative exponents, 0.5*2^-3 / -0.5*2^4
        push_op(mk(0, -3, 0), mk(1, 4, 0), {1'b0, mk(1, -6, 0)}, "R2");
        // R3: 0.75 / 0.5 = 1.5 -> 0.75 * 2^1
        push_op(mk(0, 0, 1 << (MW-1)), mk(0, 0, 0), {1'b0, mk(0, 1, 1 << (MW-1))}, "R3");
        // R4: discarded bit is one, fraction rounds 5462 -> 5463
        push_op(mk(0, 0, 1), mk(0, 0, 1 << (MW-1)), {1'b0, mk(0, 0, 5463)}, "R4");
        send(mk(1, 7, FULL), mk(1, 2, 0), "R3");
        send(mk(0, 2, 0), mk(0, 5, FULL), "R2");

        // R6: zero divisor, including negative zero and zero over zero
        push_op(mk(0, 5, 123), mk(0, EMIN, 0), {1'b1, mk(0, EMAX, FULL)}, "R6");
        push_op(mk(0, 5, 123), mk(1, EMIN, 77), {1'b1, mk(1, EMAX, FULL)}, "R6");
        push_op(mk(1, EMIN, 0), mk(0, EMIN, 0), {1'b1, mk(1, EMAX, FULL)}, "R6");
        // R7: zero dividend
        push_op(mk(1, EMIN, 5), mk(0, 3, 9), {1'b0, mk(0, EMIN, 0)}, "R7");

        // R8: overflow limits
        push_op(mk(0, EMAX, 0), mk(0, 0, FULL), {1'b0, model(mk(0, EMAX, 0), mk(0, 0, FULL))}[W:0], "R8");
        push_op(mk(1, EMAX, FULL), mk(0, 0, 0), {1'b0, mk(1, EMAX, FULL)}, "R8");
        push_op(mk(0, EMAX, 0), mk(0, EMIN+1, 0), {1'b0, mk(0, EMAX, FULL)}, "R8");
        // R9: underflow limits
        send(mk(0, EMIN+1, 0), mk(0, 0, FULL), "R9");
        push_op(mk(1, EMIN+1, 0), mk(0, 1, FULL), {1'b0, mk(0, EMIN, 0)}, "R9");
        push_op(mk(0, EMIN+1, 0), mk(0, EMAX, 0), {1'b0, mk(0, EMIN, 0)}, "R9");
        send(mk(1, EMIN+1, FULL), mk(1, 0, 0), "R9");

        // R5 and R4: back-to-back random stream with occasional gaps
        for (int i = 0; i < 150; i++) begin
            send(mk(1'($urandom_range(0, 1)), int'($urandom_range(0, 62)) - 31, int'($urandom_range(0, FULL))),
                 mk(1'($urandom_range(0, 1)), int'($urandom_range(0, 62)) - 31, int'($urandom_range(0, FULL))),
                 "R4/R5");
            if ($urandom_range(0, 7) == 0) idle(1);
        end
        idle(LAT + 4);

        // R10: reset while operations are in flight
        for (int i = 0; i < 3; i++) send(mk(0, 1, i), mk(0, 0, 3 * i), "R10");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        pend.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bad = 1'b0;
        repeat (LAT + 3) begin
            @(negedge clk);
            if (out_valid !== 1'b0) bad = 1'b1;
        end
        compared++;
        if (bad) begin
            mismatched++;
            $display("FAIL R10: actual output after reset, expected none");
        end

        // pipeline still works after reset
        send(mk(0, 0, 1 << (MW-1)), mk(0, 0, 0), "R10");
        idle(LAT + 4);

        compared++;
        if (pend.size() != 0) begin
            mismatched++;
            $display("FAIL R5: actual %0d results missing, expected 0", pend.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule